// File: doc/BRIEF.md
# Key-Encapsulation Command Dispatch Register Slice

This block is the software-facing register window of a lattice key-encapsulation accelerator. Firmware loads a parameter-set value, two buffer addresses for the public and secret key, and a 32-byte seed held as eight words. It then writes an operation code to the command register. That write is the only way to launch work. A known code produces a one-cycle start pulse toward the external arithmetic engine, and the code travels with the pulse. An unknown code is refused at once and the refusal is reported in the status word.

The engine later returns a completion strobe, which may carry an error flag and a 4-bit error code. The slice folds that response into a status word that firmware can poll. The status word holds done in bit 0, error in bit 1 and the error code in bits 7:4. Each completion also raises one-cycle interrupt pulses for done and for error. A command written while an operation is still running is not launched. It is remembered instead and reported as a busy rejection when the running operation ends.

Top module: `kem_cmd_regs`

## Requirements
- R1: After reset, every register reads zero, eng_start is low and both interrupt outputs are low.
- R2: The parameter register (0x00), public-key address (0x08), secret-key address (0x0C) and seed words (0x20, 0x24, ... 0x3C, word i at 0x20+4i) are written with wr_en and read back with rd_en. rd_data holds the value from the cycle after the read strobe.
- R3: A write to 0x04 with a known code in bits 7:0 while idle does three things. It drives eng_start high for exactly the next cycle, with eng_cmd equal to the code. It clears done, error and the error code. It makes 0x04 read back the code. The known codes are 0x01, 0x02, 0x03, 0x10, 0x11, 0x20 and 0xFF.
- R4: A write to 0x04 with any other code while idle does not pulse eng_start and leaves eng_cmd unchanged. The status word becomes 0x13 (done=1, error=1, code=1) in the next cycle.
- R5: When eng_done is seen while an operation runs, the status word sets done. Error and the error code are taken from eng_err and eng_err_code, so 0x01 on success and 0x53 for code 5.
- R6: A command write while an operation runs does not pulse eng_start. When that operation ends, the status word reads 0x23 (error code 2).
- R7: Each event that sets done gives a one-cycle pulse on irq_done. An event that also sets error gives a simultaneous one-cycle pulse on irq_err.
- R8: Writes to the status offset 0x10, to unmapped offsets or to non-word-aligned addresses change nothing. Reads of unmapped offsets return zero.
- R9: eng_done while no operation runs changes no status bit and raises no interrupt.
- R10: A command write in the same cycle that eng_done ends the running operation counts as a write during the operation. It is rejected with status 0x23.
- R11: eng_param, eng_pk_addr, eng_sk_addr and eng_seed (word i at bits 32i+31:32i) always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, registered |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_cmd | output | 8 | Operation code of the accepted command |
| eng_param | output | 32 | Parameter-set register |
| eng_pk_addr | output | 32 | Public-key buffer address |
| eng_sk_addr | output | 32 | Secret-key buffer address |
| eng_seed | output | 256 | Seed, word i at bits 32i+31:32i |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Engine error flag, valid with eng_done |
| eng_err_code | input | 4 | Engine error code, valid with eng_done |
| irq_done | output | 1 | Done interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
Two events can land in the same cycle: the engine's completion strobe and a firmware command write. The bench provokes this by raising eng_done and the command write on the same falling edge. It then checks that no start pulse follows, that done and error interrupts fire together, and that the status reads 0x23. The busy-rejection path is also exercised on its own, with a write a few cycles before completion, so the result can be told apart from a launch on the freed engine.

// File: rtl/kem_cmd_pkg.sv
package kem_cmd_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int CMD_W      = 8;
    localparam int CODE_W     = 4;
    localparam int SEED_WORDS = 8;

    localparam logic [7:0] OFF_PARAM = 8'h00;
    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_PK    = 8'h08;
    localparam logic [7:0] OFF_SK    = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_SEED  = 8'h20;

    localparam logic [CODE_W-1:0] ERR_BAD_OP = 4'd1;
    localparam logic [CODE_W-1:0] ERR_BUSY   = 4'd2;

    function automatic logic op_known(input logic [CMD_W-1:0] c);
        case (c)
            8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h20, 8'hFF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    typedef struct packed {
        logic              busy;
        logic              pend_rej;
        logic              done;
        logic              err;
        logic [CODE_W-1:0] code;
        logic [CMD_W-1:0]  cmd;
        logic              start;
        logic              irq_done;
        logic              irq_err;
    } ctrl_t;
endpackage

// File: rtl/kem_seed_dec.sv
module kem_seed_dec
    import kem_cmd_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int WORDS = SEED_WORDS
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [WORDS-1:0] sel
);
    localparam logic [AW-1:0] BASE = AW'(OFF_SEED);
    localparam logic [AW:0]   SPAN = (AW+1)'(4 * WORDS);

    logic [AW-1:0] off;

    assign off = addr - BASE;
    assign hit = (addr >= BASE) && ({1'b0, off} < SPAN) && (off[1:0] == 2'b00);

    for (genvar i = 0; i < WORDS; i++) begin : g_sel
        assign sel[i] = hit && (off[AW-1:2] == (AW-2)'(i));
    end
endmodule

// File: rtl/kem_reg_file.sv
module kem_reg_file
    import kem_cmd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int WORDS = SEED_WORDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [DW-1:0]             param_q,
    output logic [DW-1:0]             pk_q,
    output logic [DW-1:0]             sk_q,
    output logic [WORDS-1:0][DW-1:0]  seed_q
);
    typedef struct packed {
        logic [DW-1:0]            param;
        logic [DW-1:0]            pk;
        logic [DW-1:0]            sk;
        logic [WORDS-1:0][DW-1:0] seed;
    } regs_t;

    regs_t             r_d, r_q;
    logic              seed_hit;
    logic [WORDS-1:0]  seed_sel;

    kem_seed_dec #(.AW(AW), .WORDS(WORDS)) u_wdec (
        .addr (wr_addr),
        .hit  (seed_hit),
        .sel  (seed_sel)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == AW'(OFF_PARAM)) r_d.param = wr_data;
            if (wr_addr == AW'(OFF_PK))    r_d.pk    = wr_data;
            if (wr_addr == AW'(OFF_SK))    r_d.sk    = wr_data;
            for (int i = 0; i < WORDS; i++) begin
                if (seed_sel[i]) r_d.seed[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign param_q = r_q.param;
    assign pk_q    = r_q.pk;
    assign sk_q    = r_q.sk;
    assign seed_q  = r_q.seed;
endmodule

// File: rtl/kem_cmd_ctrl.sv
module kem_cmd_ctrl
    import kem_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [CODE_W-1:0] eng_err_code,
    output logic              eng_start,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CODE_W-1:0] code,
    output logic              irq_done,
    output logic              irq_err
);
    ctrl_t c_d, c_q;
    logic  finish;

    assign finish = c_q.busy && eng_done;

    always_comb begin
        c_d          = c_q;
        c_d.start    = 1'b0;
        c_d.irq_done = 1'b0;
        c_d.irq_err  = 1'b0;
        if (finish) begin
            // completion wins; a write in this cycle still counts as in flight
            c_d.busy     = 1'b0;
            c_d.pend_rej = 1'b0;
            c_d.done     = 1'b1;
            c_d.irq_done = 1'b1;
            if (c_q.pend_rej || cmd_wr) begin
                c_d.err     = 1'b1;
                c_d.code    = ERR_BUSY;
                c_d.irq_err = 1'b1;
            end else if (eng_err) begin
                c_d.err     = 1'b1;
                c_d.code    = eng_err_code;
                c_d.irq_err = 1'b1;
            end else begin
                c_d.err  = 1'b0;
                c_d.code = '0;
            end
        end else if (cmd_wr) begin
            if (c_q.busy) begin
                c_d.pend_rej = 1'b1;
            end else if (op_known(cmd_data)) begin
                c_d.busy  = 1'b1;
                c_d.start = 1'b1;
                c_d.cmd   = cmd_data;
                c_d.done  = 1'b0;
                c_d.err   = 1'b0;
                c_d.code  = '0;
            end else begin
                c_d.done     = 1'b1;
                c_d.err      = 1'b1;
                c_d.code     = ERR_BAD_OP;
                c_d.irq_done = 1'b1;
                c_d.irq_err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign eng_start = c_q.start;
    assign eng_cmd   = c_q.cmd;
    assign busy      = c_q.busy;
    assign done      = c_q.done;
    assign err       = c_q.err;
    assign code      = c_q.code;
    assign irq_done  = c_q.irq_done;
    assign irq_err   = c_q.irq_err;
endmodule

// File: rtl/kem_rd_mux.sv
module kem_rd_mux
    import kem_cmd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int WORDS = SEED_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [AW-1:0]            rd_addr,
    input  logic [DW-1:0]            param,
    input  logic [DW-1:0]            cmd_word,
    input  logic [DW-1:0]            pk,
    input  logic [DW-1:0]            sk,
    input  logic [DW-1:0]            stat_word,
    input  logic [WORDS-1:0][DW-1:0] seed,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0]    rd_d, rd_q;
    logic             seed_hit;
    logic [WORDS-1:0] seed_sel;

    kem_seed_dec #(.AW(AW), .WORDS(WORDS)) u_rdec (
        .addr (rd_addr),
        .hit  (seed_hit),
        .sel  (seed_sel)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = '0;
            if (rd_addr == AW'(OFF_PARAM)) rd_d = param;
            if (rd_addr == AW'(OFF_CMD))   rd_d = cmd_word;
            if (rd_addr == AW'(OFF_PK))    rd_d = pk;
            if (rd_addr == AW'(OFF_SK))    rd_d = sk;
            if (rd_addr == AW'(OFF_STAT))  rd_d = stat_word;
            for (int i = 0; i < WORDS; i++) begin
                if (seed_hit && seed_sel[i]) rd_d = seed[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/kem_cmd_regs.sv
module kem_cmd_regs
    import kem_cmd_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int WORDS = SEED_WORDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    input  logic [AW-1:0]         rd_addr,
    output logic [DW-1:0]         rd_data,
    output logic                  eng_start,
    output logic [CMD_W-1:0]      eng_cmd,
    output logic [DW-1:0]         eng_param,
    output logic [DW-1:0]         eng_pk_addr,
    output logic [DW-1:0]         eng_sk_addr,
    output logic [WORDS*DW-1:0]   eng_seed,
    input  logic                  eng_done,
    input  logic                  eng_err,
    input  logic [CODE_W-1:0]     eng_err_code,
    output logic                  irq_done,
    output logic                  irq_err
);
    logic [WORDS-1:0][DW-1:0] seed_q;
    logic                     cmd_wr;
    logic                     busy_w, done_w, err_w;
    logic [CODE_W-1:0]        code_w;
    logic [DW-1:0]            stat_word, cmd_word;

    assign cmd_wr = wr_en && (wr_addr == AW'(OFF_CMD));

    kem_reg_file #(.DW(DW), .AW(AW), .WORDS(WORDS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .param_q (eng_param),
        .pk_q    (eng_pk_addr),
        .sk_q    (eng_sk_addr),
        .seed_q  (seed_q)
    );

    kem_cmd_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_data     (wr_data[CMD_W-1:0]),
        .eng_done     (eng_done),
        .eng_err      (eng_err),
        .eng_err_code (eng_err_code),
        .eng_start    (eng_start),
        .eng_cmd      (eng_cmd),
        .busy         (busy_w),
        .done         (done_w),
        .err          (err_w),
        .code         (code_w),
        .irq_done     (irq_done),
        .irq_err      (irq_err)
    );

    assign stat_word = {{(DW-8){1'b0}}, code_w, 2'b00, err_w, done_w};
    assign cmd_word  = {{(DW-CMD_W){1'b0}}, eng_cmd};
    assign eng_seed  = seed_q;

    kem_rd_mux #(.DW(DW), .AW(AW), .WORDS(WORDS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .param     (eng_param),
        .cmd_word  (cmd_word),
        .pk        (eng_pk_addr),
        .sk        (eng_sk_addr),
        .stat_word (stat_word),
        .seed      (seed_q),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/kem_cmd_chk.sv
module kem_cmd_chk
    import kem_cmd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [CMD_W-1:0]  wr_cmd,
    input logic              eng_start,
    input logic              eng_done,
    input logic              irq_done,
    input logic              irq_err,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [CODE_W-1:0] code
);
    logic cmd_hit;
    assign cmd_hit = wr_en && (wr_addr == AW'(OFF_CMD));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (busy && !done && !err && code == '0));

    assert_bad_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !busy && !op_known(wr_cmd)) |=>
            (done && err && code == ERR_BAD_OP && !eng_start));

    assert_busy_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy) |=> !eng_start);

    assert_irq_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (done && !busy));

    assert_irq_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (irq_done && err));

    assert_idle_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && eng_done && !cmd_hit) |=>
            (done == $past(done) && err == $past(err) && code == $past(code) && !irq_done));

    assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && cmd_hit) |=> (err && code == ERR_BUSY && !eng_start));
endmodule

bind kem_cmd_regs kem_cmd_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_cmd    (wr_data[7:0]),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .irq_done  (irq_done),
    .irq_err   (irq_err),
    .busy      (busy_w),
    .done      (done_w),
    .err       (err_w),
    .code      (code_w)
);

// File: tb/tb_kem_cmd_regs.sv
module tb_kem_cmd_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         eng_start;
    logic [7:0]   eng_cmd;
    logic [31:0]  eng_param, eng_pk_addr, eng_sk_addr;
    logic [255:0] eng_seed;
    logic         eng_done = 1'b0;
    logic         eng_err = 1'b0;
    logic [3:0]   eng_err_code = '0;
    logic         irq_done, irq_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    kem_cmd_regs dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .eng_start(eng_start), .eng_cmd(eng_cmd), .eng_param(eng_param),
        .eng_pk_addr(eng_pk_addr), .eng_sk_addr(eng_sk_addr), .eng_seed(eng_seed),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_code(eng_err_code),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic eng_reply(input logic e, input logic [3:0] c);
        @(negedge clk);
        eng_done = 1'b1; eng_err = e; eng_err_code = c;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_err_code = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 eng_start", {31'b0, eng_start}, 32'h0);
        check("R1 irq", {30'b0, irq_done, irq_err}, 32'h0);
        bus_rd(8'h10, v); check("R1 status", v, 32'h0);
        bus_rd(8'h00, v); check("R1 param", v, 32'h0);
        bus_rd(8'h3C, v); check("R1 seed7", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_wr(8'h00, 32'h3);
        bus_wr(8'h08, 32'h2000);
        bus_wr(8'h0C, 32'h4000);
        for (int i = 0; i < 8; i++) bus_wr(8'h20 + 8'(4*i), 32'hA500_0000 | i);
        bus_rd(8'h00, v); check("R2 param", v, 32'h3);
        bus_rd(8'h08, v); check("R2 pk", v, 32'h2000);
        bus_rd(8'h0C, v); check("R2 sk", v, 32'h4000);
        for (int i = 0; i < 8; i++) begin
            bus_rd(8'h20 + 8'(4*i), v); check("R2 seed", v, 32'hA500_0000 | i);
        end
        check("R11 eng_param", eng_param, 32'h3);
        check("R11 eng_pk", eng_pk_addr, 32'h2000);
        check("R11 eng_sk", eng_sk_addr, 32'h4000);
        for (int i = 0; i < 8; i++) check("R11 eng_seed", eng_seed[32*i +: 32], 32'hA500_0000 | i);
    endtask

    task automatic t_valid();
        logic [31:0] v;
        logic [7:0] ops [7] = '{8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h20, 8'hFF};
        for (int i = 0; i < 7; i++) begin
            bus_wr(8'h04, {24'h0, ops[i]});
            check("R3 start", {31'b0, eng_start}, 32'h1);
            check("R3 eng_cmd", {24'h0, eng_cmd}, {24'h0, ops[i]});
            @(negedge clk);
            check("R3 one-cycle start", {31'b0, eng_start}, 32'h0);
            eng_reply(1'b0, 4'h0);
            check("R7 irq ok", {30'b0, irq_done, irq_err}, 32'h2);
            @(negedge clk);
            check("R7 irq_done drops", {31'b0, irq_done}, 32'h0);
            bus_rd(8'h10, v); check("R5 status ok", v, 32'h01);
            bus_rd(8'h04, v); check("R3 cmd readback", v, {24'h0, ops[i]});
        end
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        logic [7:0] bad [3] = '{8'h07, 8'h00, 8'h12};
        for (int i = 0; i < 3; i++) begin
            bus_wr(8'h04, {24'h0, bad[i]});
            check("R4 no start", {31'b0, eng_start}, 32'h0);
            check("R7 irq bad op", {30'b0, irq_done, irq_err}, 32'h3);
            @(negedge clk);
            check("R7 irq one cycle", {30'b0, irq_done, irq_err}, 32'h0);
            bus_rd(8'h10, v); check("R4 status", v, 32'h13);
            check("R4 eng_cmd kept", {24'h0, eng_cmd}, 32'hFF);
        end
    endtask

    task automatic t_clear_and_err();
        logic [31:0] v;
        bus_wr(8'h04, 32'h01);
        check("R3 start after bad", {31'b0, eng_start}, 32'h1);
        bus_rd(8'h10, v); check("R3 status cleared", v, 32'h0);
        eng_reply(1'b1, 4'h5);
        check("R5 irq err", {30'b0, irq_done, irq_err}, 32'h3);
        bus_rd(8'h10, v); check("R5 status err", v, 32'h53);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        bus_wr(8'h04, 32'h02);
        check("R3 start", {31'b0, eng_start}, 32'h1);
        @(negedge clk);
        bus_wr(8'h04, 32'h03);
        check("R6 no start", {31'b0, eng_start}, 32'h0);
        check("R6 eng_cmd kept", {24'h0, eng_cmd}, 32'h02);
        bus_rd(8'h10, v); check("R6 status while busy", v, 32'h0);
        eng_reply(1'b0, 4'h0);
        check("R6 irq", {30'b0, irq_done, irq_err}, 32'h3);
        bus_rd(8'h10, v); check("R6 status", v, 32'h23);
    endtask

    task automatic t_idle_resp();
        logic [31:0] v;
        eng_reply(1'b1, 4'h9);
        check("R9 no irq", {30'b0, irq_done, irq_err}, 32'h0);
        bus_rd(8'h10, v); check("R9 status kept", v, 32'h23);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        bus_wr(8'h04, 32'h20);
        check("R10 start", {31'b0, eng_start}, 32'h1);
        @(negedge clk);
        eng_done = 1'b1; wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'h01;
        @(negedge clk);
        eng_done = 1'b0; wr_en = 1'b0;
        check("R10 no start", {31'b0, eng_start}, 32'h0);
        check("R10 irq", {30'b0, irq_done, irq_err}, 32'h3);
        bus_rd(8'h10, v); check("R10 status", v, 32'h23);
        bus_rd(8'h04, v); check("R10 cmd kept", v, 32'h20);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, v); check("R8 status write ignored", v, 32'h23);
        bus_wr(8'h14, 32'h1234_5678);
        bus_rd(8'h14, v); check("R8 unmapped read", v, 32'h0);
        bus_rd(8'h40, v); check("R8 past seed", v, 32'h0);
        bus_wr(8'h02, 32'hDEAD_BEEF);
        bus_rd(8'h00, v); check("R8 misaligned ignored", v, 32'h3);
        bus_wr(8'h21, 32'hDEAD_BEEF);
        bus_rd(8'h20, v); check("R8 misaligned seed", v, 32'hA500_0000);
        check("R8 no start", {31'b0, eng_start}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_valid();
        t_invalid();
        t_clear_and_err();
        t_busy();
        t_idle_resp();
        t_collide();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule